// File: doc/BRIEF.md
# Multiplexed Bus Address Latch Front End

This block sits between an 8-bit microcontroller with a shared address/data bus and the decoders and register files behind it. While the address strobe is asserted, it tracks the low address byte on the shared lines, the high byte, and up to four extra upper address bits. When the strobe ends, it commits them as one stable address word. Each upper bit can instead pass straight through as a transparent logic input.

The raw control pins are turned into registered qualifiers for read, write, program fetch and reset, plus an output enable for the data drivers. Static strap inputs pick the strobe polarity, the reset-pin polarity, the write style (write pulse or read/write level) and the read style (read pulse or enable clock). A build parameter can fix the reset pin to active-low. All pins are sampled on the system clock. Qualifiers appear one clock after the pins are sampled. A committed address appears one clock after the first cycle in which the strobe is seen inactive.

Top module: `mbus_latch_front`

## Requirements
- R1: The latched address bits change only one clock after a cycle where the strobe is sampled inactive after being sampled active. The committed value is the one on the pins in the last active cycle. A leading edge of the strobe, or a strobe held active, leaves the latched address unchanged.
- R2: The strobe is active when `strobe_in` differs from `cfg_as_low`. This means active-high when the strap is 0 and active-low when it is 1.
- R3: `addr_out[15:8]` is committed from `a_hi_in` on the same trailing edge as `addr_out[7:0]` from `ad_in`.
- R4: For each bit i, `cfg_up_latch[i]`=1 makes `addr_out[16+i]` latched like the low byte. `cfg_up_latch[i]`=0 makes it follow `a_up_in[i]` with no clock delay.
- R5: `wr_q` is 1 one clock after `wr_in` is low when `cfg_rw_level`=0. When `cfg_rw_level`=1, it is 1 one clock after the read enable is active with `wr_in` low.
- R6: The read enable is `rd_in` low when `cfg_e_clock`=0 and `rd_in` high when `cfg_e_clock`=1. `rd_q` is 1 one clock after the read enable is active and, if `cfg_rw_level`=1, `wr_in` is high.
- R7: `fetch_q` is 1 one clock after `psen_n` is low, independent of `rd_q`.
- R8: The reset pin is active-high when `cfg_rst_high`=1 and active-low otherwise. `rst_q` follows its active state one clock later.
- R9: With `FIXED_RST_LOW`=1 the reset pin is active-low whatever `cfg_rst_high` holds.
- R10: `data_oe` is 1 one clock after a cycle with `rd_q` or `fetch_q` being set, `sel_n` low and the strobe inactive; otherwise it is 0.
- R11: While `rst_n` is low or the reset pin is active, all latched address bits and all of `rd_q`, `wr_q`, `fetch_q` and `data_oe` clear to 0 at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cfg_as_low | input | 1 | Strap: strobe active-low when 1 |
| cfg_rst_high | input | 1 | Strap: reset pin active-high when 1 |
| cfg_rw_level | input | 1 | Strap: `wr_in` is a read/write level when 1 |
| cfg_e_clock | input | 1 | Strap: `rd_in` is an active-high enable clock when 1 |
| cfg_up_latch | input | UP_W | Per upper bit: 1 latched, 0 transparent |
| ad_in | input | LO_W | Shared low address/data lines |
| a_hi_in | input | HI_W | High address byte |
| a_up_in | input | UP_W | Extra upper address bits |
| strobe_in | input | 1 | Address strobe pin |
| wr_in | input | 1 | Write pulse or read/write level |
| rd_in | input | 1 | Read pulse or enable clock |
| psen_n | input | 1 | Program fetch strobe, active-low |
| rst_pin | input | 1 | Bus reset pin, polarity per strap |
| sel_n | input | 1 | Device select, active-low |
| addr_out | output | LO_W+HI_W+UP_W | Latched/transparent address word |
| rd_q | output | 1 | Qualified data read |
| wr_q | output | 1 | Qualified write |
| fetch_q | output | 1 | Qualified program fetch |
| rst_q | output | 1 | Qualified bus reset |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach is one where the shared lines already carry data in the cycle the strobe is first seen inactive. A design that samples at that moment would commit the data byte, not the address. The stimulus changes `ad_in` in that very cycle and expects the earlier address. It also holds the strobe active across several different `ad_in` values, and it raises the strobe while a read is pending, which shows that only the last active value is committed. The strobe polarity strap is flipped mid-run with the pin moved so that no false edge appears. The fixed-reset build runs alongside the configurable one on the same pins.

// File: rtl/mbf_pkg.sv
// Package: shared types for the multiplexed bus front end.
// Assumes all consumers sample qualifiers on the same clock.
package mbf_pkg;

    // Registered bus-cycle qualifiers produced by the cycle decoder.
    typedef struct packed {
        logic rd;
        logic wr;
        logic fetch;
        logic oe;
    } mbf_qual_t;

endpackage

// File: rtl/mbf_strobe_edge.sv
// Strobe polarity normaliser and trailing-edge detector.
// Assumes strobe_pin is already synchronous to clk.
module mbf_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic strobe_pin,
    input  logic active_low,
    output logic act,
    output logic trail
);

    logic prev_act;

    assign act   = strobe_pin ^ active_low;
    assign trail = prev_act & ~act;

    // Remember last cycle's strobe state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) prev_act <= 1'b0;
        else               prev_act <= act;
    end

endmodule

// File: rtl/mbf_addr_latch.sv
// Two-stage address latch: a shadow stage tracks the pins while the
// strobe is active, the output stage commits it on the trailing edge.
// Bits with byp set pass the pin through with no clock delay.
module mbf_addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         track,
    input  logic         commit,
    input  logic [W-1:0] d,
    input  logic [W-1:0] byp,
    output logic [W-1:0] q,
    output logic [W-1:0] y
);

    logic [W-1:0] shadow;

    // Follow the pins during the active strobe phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) shadow <= '0;
        else if (track)    shadow <= d;
    end

    // Commit the tracked value once the strobe has ended.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (commit)   q <= shadow;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = byp[i] ? d[i] : q[i];
    end

endmodule

// File: rtl/mbf_reset_qual.sv
// Bus reset pin qualifier with strap or fixed active-low polarity.
// Assumes rst_pin is synchronous to clk.
module mbf_reset_qual #(
    parameter bit FIXED_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    input  logic cfg_high,
    output logic bus_rst,
    output logic rst_q
);

    localparam bit ALLOW_HIGH = !FIXED_LOW;

    logic pol_high;

    assign pol_high = ALLOW_HIGH & cfg_high;
    assign bus_rst  = pol_high ? rst_pin : ~rst_pin;

    // Register the qualified reset for downstream logic.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= bus_rst;
    end

endmodule

// File: rtl/mbf_cycle_decode.sv
// Decodes read, write and fetch strobes in either bus style and
// derives the data output enable. Outputs are registered.
module mbf_cycle_decode
    import mbf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_rst,
    input  logic      strobe_act,
    input  logic      rd_pin,
    input  logic      wr_pin,
    input  logic      psen_n,
    input  logic      sel_n,
    input  logic      cfg_rw_level,
    input  logic      cfg_e_clock,
    output mbf_qual_t qual
);

    logic      enable;
    mbf_qual_t nxt;

    // Combinational strobe decode for both bus styles.
    always_comb begin
        enable    = cfg_e_clock ? rd_pin : ~rd_pin;
        nxt.rd    = cfg_rw_level ? (enable & wr_pin) : enable;
        nxt.wr    = cfg_rw_level ? (enable & ~wr_pin) : ~wr_pin;
        nxt.fetch = ~psen_n;
        nxt.oe    = (nxt.rd | nxt.fetch) & ~sel_n & ~strobe_act;
    end

    // Register qualifiers, cleared during either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst) qual <= '0;
        else                   qual <= nxt;
    end

endmodule

// File: rtl/mbus_latch_front.sv
// Top: multiplexed bus address latch and strobe qualifier.
// Assumes every bus pin is synchronous to clk; straps are static
// except when the strobe pin is held so no false edge appears.
module mbus_latch_front
    import mbf_pkg::*;
#(
    parameter int LO_W          = 8,
    parameter int HI_W          = 8,
    parameter int UP_W          = 4,
    parameter bit FIXED_RST_LOW = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_as_low,
    input  logic                       cfg_rst_high,
    input  logic                       cfg_rw_level,
    input  logic                       cfg_e_clock,
    input  logic [UP_W-1:0]            cfg_up_latch,
    input  logic [LO_W-1:0]            ad_in,
    input  logic [HI_W-1:0]            a_hi_in,
    input  logic [UP_W-1:0]            a_up_in,
    input  logic                       strobe_in,
    input  logic                       wr_in,
    input  logic                       rd_in,
    input  logic                       psen_n,
    input  logic                       rst_pin,
    input  logic                       sel_n,
    output logic [LO_W+HI_W+UP_W-1:0] addr_out,
    output logic                       rd_q,
    output logic                       wr_q,
    output logic                       fetch_q,
    output logic                       rst_q,
    output logic                       data_oe
);

    localparam int ADDR_W = LO_W + HI_W + UP_W;

    logic              strobe_act;
    logic              strobe_trail;
    logic              bus_rst;
    logic [LO_W-1:0]   lo_q, lo_y;
    logic [HI_W-1:0]   hi_q, hi_y;
    logic [UP_W-1:0]   up_q, up_y;
    logic [ADDR_W-1:0] lat_word;
    mbf_qual_t         qual;

    mbf_reset_qual #(.FIXED_LOW(FIXED_RST_LOW)) u_rst (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin),
        .cfg_high(cfg_rst_high), .bus_rst(bus_rst), .rst_q(rst_q)
    );

    mbf_strobe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .clr(bus_rst), .strobe_pin(strobe_in),
        .active_low(cfg_as_low), .act(strobe_act), .trail(strobe_trail)
    );

    mbf_addr_latch #(.W(LO_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .clr(bus_rst), .track(strobe_act),
        .commit(strobe_trail), .d(ad_in), .byp('0), .q(lo_q), .y(lo_y)
    );

    mbf_addr_latch #(.W(HI_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr(bus_rst), .track(strobe_act),
        .commit(strobe_trail), .d(a_hi_in), .byp('0), .q(hi_q), .y(hi_y)
    );

    mbf_addr_latch #(.W(UP_W)) u_up (
        .clk(clk), .rst_n(rst_n), .clr(bus_rst), .track(strobe_act),
        .commit(strobe_trail), .d(a_up_in), .byp(~cfg_up_latch),
        .q(up_q), .y(up_y)
    );

    mbf_cycle_decode u_dec (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .strobe_act(strobe_act),
        .rd_pin(rd_in), .wr_pin(wr_in), .psen_n(psen_n), .sel_n(sel_n),
        .cfg_rw_level(cfg_rw_level), .cfg_e_clock(cfg_e_clock), .qual(qual)
    );

    assign lat_word = {up_q, hi_q, lo_q};
    assign addr_out = {up_y, hi_y, lo_y};
    assign rd_q     = qual.rd;
    assign wr_q     = qual.wr;
    assign fetch_q  = qual.fetch;
    assign data_oe  = qual.oe;

endmodule

// File: rtl/mbf_front_chk.sv
// Checker for mbus_latch_front, attached by bind below.
module mbf_front_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strobe_act,
    input logic          strobe_trail,
    input logic          bus_rst,
    input logic          psen_n,
    input logic          sel_n,
    input logic [AW-1:0] lat_word,
    input logic          rd_q,
    input logic          wr_q,
    input logic          fetch_q,
    input logic          rst_q,
    input logic          data_oe
);

    // R1
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_trail && !bus_rst) |=> $stable(lat_word));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (lat_word == '0 && !rd_q && !wr_q && !fetch_q && !data_oe));

    // R8
    reset_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> rst_q);

    // R10
    oe_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_act |=> !data_oe);

    // R10
    oe_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !data_oe);

    // R7
    fetch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n && !bus_rst) |=> fetch_q);

endmodule

bind mbus_latch_front mbf_front_chk #(.AW(LO_W+HI_W+UP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe_act(strobe_act),
    .strobe_trail(strobe_trail), .bus_rst(bus_rst), .psen_n(psen_n),
    .sel_n(sel_n), .lat_word(lat_word), .rd_q(rd_q), .wr_q(wr_q),
    .fetch_q(fetch_q), .rst_q(rst_q), .data_oe(data_oe)
);

// File: tb/mbus_latch_front_bench.sv
`timescale 1ns/1ps
module mbus_latch_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_as_low = 0, cfg_rst_high = 0, cfg_rw_level = 0, cfg_e_clock = 0;
    logic [3:0]  cfg_up_latch = 4'b0111;
    logic [7:0]  ad_in = 0, a_hi_in = 0;
    logic [3:0]  a_up_in = 0;
    logic        strobe_in = 0, wr_in = 1, rd_in = 1, psen_n = 1, rst_pin = 1, sel_n = 0;
    logic [19:0] addr_out, f_addr;
    logic        rd_q, wr_q, fetch_q, rst_q, data_oe;
    logic        f_rd, f_wr, f_fetch, f_rst, f_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [24:0] v;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    mbus_latch_front u_mbus_latch_front (
        .clk, .rst_n, .cfg_as_low, .cfg_rst_high, .cfg_rw_level, .cfg_e_clock,
        .cfg_up_latch, .ad_in, .a_hi_in, .a_up_in, .strobe_in, .wr_in, .rd_in,
        .psen_n, .rst_pin, .sel_n, .addr_out, .rd_q, .wr_q, .fetch_q,
        .rst_q, .data_oe
    );

    mbus_latch_front #(.FIXED_RST_LOW(1'b1)) u_fixed (
        .clk, .rst_n, .cfg_as_low, .cfg_rst_high, .cfg_rw_level, .cfg_e_clock,
        .cfg_up_latch, .ad_in, .a_hi_in, .a_up_in, .strobe_in, .wr_in, .rd_in,
        .psen_n, .rst_pin, .sel_n, .addr_out(f_addr), .rd_q(f_rd), .wr_q(f_wr),
        .fetch_q(f_fetch), .rst_q(f_rst), .data_oe(f_oe)
    );

    task automatic check(input logic [24:0] got, input logic [24:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Driver: push expectation for the next clock, then advance to its negedge.
    // Flag order {rd, wr, fetch, rst, oe}.
    task automatic tick(input logic [19:0] ea, input logic [4:0] ef, input string req);
        exp_t e;
        e.v = {ea, ef};
        e.req = req;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare design outputs against the queued expectation.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({addr_out, rd_q, wr_q, fetch_q, rst_q, data_oe}, e.v, e.req);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({addr_out, rd_q, wr_q, fetch_q, rst_q, data_oe}, 25'h0, "R11 reset state");
        rst_n = 1'b1;
        tick(20'h00000, 5'b00000, "R11 idle");
        strobe_in = 1; ad_in = 8'h34; a_hi_in = 8'h12; a_up_in = 4'b1101;
        tick(20'h80000, 5'b00000, "R4 transparent bit / R1 leading edge");
        strobe_in = 0; ad_in = 8'hAA; a_up_in = 4'b0101;
        tick(20'h51234, 5'b00000, "R1 R3 R4 trailing commit");
        rd_in = 0;
        tick(20'h51234, 5'b10001, "R6 R10 read pulse");
        sel_n = 1;
        tick(20'h51234, 5'b10000, "R10 deselected");
        rd_in = 1; sel_n = 0; psen_n = 0;
        tick(20'h51234, 5'b00101, "R7 fetch");
        psen_n = 1; wr_in = 0;
        tick(20'h51234, 5'b01000, "R5 write pulse");
        wr_in = 1; rd_in = 0; strobe_in = 1; ad_in = 8'h56; a_hi_in = 8'h78; a_up_in = 4'b0000;
        tick(20'h51234, 5'b10000, "R10 strobe blocks oe");
        rd_in = 1; ad_in = 8'h99;
        tick(20'h51234, 5'b00000, "R1 held while active");
        strobe_in = 0; ad_in = 8'h00;
        tick(20'h07899, 5'b00000, "R1 last active value");
        cfg_as_low = 1; strobe_in = 1; ad_in = 8'h11;
        tick(20'h07899, 5'b00000, "R2 polarity switch");
        strobe_in = 0; ad_in = 8'h22; a_hi_in = 8'h33;
        tick(20'h07899, 5'b00000, "R2 active-low strobe");
        strobe_in = 1; ad_in = 8'hEE;
        tick(20'h03322, 5'b00000, "R2 active-low commit");
        cfg_rw_level = 1; cfg_e_clock = 1; rd_in = 0; wr_in = 1;
        tick(20'h03322, 5'b00000, "R6 enable low idle");
        rd_in = 1;
        tick(20'h03322, 5'b10001, "R6 enable clock read");
        wr_in = 0;
        tick(20'h03322, 5'b01000, "R5 level write");
        cfg_rw_level = 0; cfg_e_clock = 0; rd_in = 1; wr_in = 1;
        tick(20'h03322, 5'b00000, "R6 idle");
        rst_pin = 0; rd_in = 0;
        tick(20'h00000, 5'b00010, "R8 R11 low reset");
        rst_pin = 1; rd_in = 1;
        tick(20'h00000, 5'b00000, "R8 release");
        strobe_in = 0; ad_in = 8'h5A; a_hi_in = 8'h00;
        tick(20'h00000, 5'b00000, "R2 capture");
        strobe_in = 1;
        tick(20'h0005A, 5'b00000, "R2 commit");
        cfg_rst_high = 1; rst_pin = 1;
        tick(20'h00000, 5'b00010, "R8 R11 high reset");
        check({f_addr, f_rst}, {20'h0005A, 1'b0}, "R9 fixed ignores high");
        rst_pin = 0;
        tick(20'h00000, 5'b00000, "R8 high reset released");
        check({f_addr, f_rst}, {20'h00000, 1'b1}, "R9 fixed active-low");
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule